// File: doc/BRIEF.md
# Keyed-write watchdog timer

This block is a watchdog timer built around an 8-bit up-counter. The counter advances once per prescaled tick. The tick comes from a free-running divider on the single input clock. A 3-bit clock-select code picks one of eight power-of-two ratios, from one tick every 32 clocks up to one tick every 4096 clocks. When the count wraps from 0xFF to 0x00, the block latches an overflow flag. Depending on the selected mode, it then either pulses a reset request for one clock or raises an interval interrupt.

Software reaches the timer over a small bus with two registers: the counter and a control/status register. Reads are 8 bits wide. Each register is protected against stray stores. A write only lands when it is 16 bits wide and its upper byte carries the key that belongs to that register. Anything else is dropped without side effects.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the counter reads 0x00, the control/status register reads 0x00 (clock-select code 0, ratio 1/32), and both the reset request and the interrupt outputs are low.
- R2: A 16-bit write to address 0 with 0x5A in bits 15:8, made while the timer is enabled, loads bits 7:0 into the counter. It wins over a tick in the same cycle. It also zeroes the prescaler, so the next increment comes one full tick period after the write clock edge.
- R3: A 16-bit write to address 1 with 0xA5 in bits 15:8 sets enable from bit 7 and mode from bit 6. The register reads back as {enable[7], mode[6], flag[5], 2'b00[4:3], clock-select[2:0]}.
- R4: A write whose upper byte is not the key of the addressed register, and any byte-wide write, leaves the counter, enable, mode, flag and clock-select unchanged.
- R5: While enabled, the counter increments once every 2^(5+code) clocks, where code is the clock-select value. The first increment comes 2^(5+code) clocks after the enabling write or the counter write.
- R6: While enable is 0, the counter and the prescaler are held at zero, and keyed counter writes have no effect.
- R7: The count wrapping from 0xFF to 0x00 sets the flag (bit 5). A keyed control write with bit 5 at 0 clears the flag, and one with bit 5 at 1 leaves it unchanged. When an overflow and a clearing write fall on the same clock edge, the flag ends up set.
- R8: In watchdog mode (bit 6 = 1), an overflow drives the reset request high for exactly the one clock that follows the overflow edge, and the interrupt stays low.
- R9: In interval mode (bit 6 = 0), the interrupt output is high while the flag is set, and the reset request stays low.
- R10: A keyed control write updates the clock-select field only if the timer was disabled before that write. While the timer is enabled, the field keeps its value.
- R11: The read data is combinational, with 8 bits: address 0 returns the counter and address 1 returns the control/status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Access is a write |
| bus_wide | input | 1 | Write is 16 bits wide |
| bus_addr | input | 1 | Register select: 0 counter, 1 control/status |
| bus_wdata | input | 16 | Write data: key in 15:8, value in 7:0 |
| bus_rdata | output | 8 | Read data of the addressed register |
| wdt_rst_req | output | 1 | One-clock reset request on watchdog-mode overflow |
| wdt_irq | output | 1 | Interval interrupt, high while the flag is set in interval mode |

## Verification
The overflow that sets the flag and a software write that clears the flag can land on the same clock edge. The bench provokes this by loading 0xFE and then counting exactly two tick periods of clocks. It places the clearing control write on the overflow edge and expects the flag and the interrupt to read back set. In the same way, a counter write is placed on an edge where a tick is due. It is judged by reading the loaded value, not that value plus one, and by the next increment arriving a full period later.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int DW          = 8,
  parameter int SEL_W       = 3,
  parameter int MIN_DIV_LOG = 5,
  parameter logic [7:0] CNT_KEY = 8'h5A,
  parameter logic [7:0] CSR_KEY = 8'hA5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic            bus_wide,
  input  logic            bus_addr,
  input  logic [2*DW-1:0] bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            wdt_rst_req,
  output logic            wdt_irq
);
  localparam int PRE_W  = MIN_DIV_LOG + (1 << SEL_W) - 1;
  localparam int RSV_W  = DW - 3 - SEL_W;
  localparam int EN_B   = DW - 1;
  localparam int MODE_B = DW - 2;
  localparam int FLAG_B = DW - 3;

  logic [DW-1:0]    cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic [SEL_W-1:0] cks_q;
  logic             en_q, mode_q, flag_q, rst_q;

  logic [DW-1:0]    key, val;
  logic [PRE_W-1:0] tick_mask;
  logic             wr_ok, cnt_wr, csr_wr, tick, ovf;
  logic             unused_rsv;

  assign key        = bus_wdata[2*DW-1:DW];
  assign val        = bus_wdata[DW-1:0];
  assign unused_rsv = ^val[FLAG_B-1:SEL_W];

  assign wr_ok  = bus_sel & bus_wr & bus_wide;
  assign cnt_wr = wr_ok & ~bus_addr & (key == CNT_KEY);
  assign csr_wr = wr_ok &  bus_addr & (key == CSR_KEY);

  assign tick_mask = (PRE_W'(1) << (MIN_DIV_LOG + 32'(cks_q))) - PRE_W'(1);
  assign tick      = en_q & ((pre_q & tick_mask) == tick_mask);
  assign ovf       = tick & ~cnt_wr & (cnt_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else if (!en_q) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else if (cnt_wr) begin
      cnt_q <= val;
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + PRE_W'(1);
      if (tick) cnt_q <= cnt_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      cks_q  <= '0;
    end else if (csr_wr) begin
      en_q   <= val[EN_B];
      mode_q <= val[MODE_B];
      if (!en_q) cks_q <= val[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= ovf & mode_q;
      if (ovf) flag_q <= 1'b1;
      else if (csr_wr && !val[FLAG_B]) flag_q <= 1'b0;
    end
  end

  assign bus_rdata   = bus_addr ? {en_q, mode_q, flag_q, {RSV_W{1'b0}}, cks_q} : cnt_q;
  assign wdt_rst_req = rst_q;
  assign wdt_irq     = flag_q & ~mode_q;
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
  parameter int DW    = 8,
  parameter int SEL_W = 3,
  parameter logic [7:0] CNT_KEY = 8'h5A,
  parameter logic [7:0] CSR_KEY = 8'hA5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [DW-1:0]    bus_key,
  input logic             en,
  input logic             mode,
  input logic             flag,
  input logic [SEL_W-1:0] cks,
  input logic [DW-1:0]    cnt,
  input logic             rst_req
);
  // R6
  held_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !en |=> cnt == '0);

  // R10
  cks_lock_chk: assert property (@(posedge clk) disable iff (!rst_n) en |=> $stable(cks));

  // R7
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(cnt) == '1 && cnt == '0));

  // R8
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n) rst_req |=> !rst_req);

  // R8
  pulse_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> ($past(mode) && flag));

  // R4
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_key != CNT_KEY && bus_key != CSR_KEY) |=> $stable({en, mode, cks}));
endmodule

bind keyed_wdt keyed_wdt_chk #(
  .DW(DW), .SEL_W(SEL_W), .CNT_KEY(CNT_KEY), .CSR_KEY(CSR_KEY)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_sel (bus_sel),
  .bus_wr  (bus_wr),
  .bus_key (bus_wdata[2*DW-1:DW]),
  .en      (en_q),
  .mode    (mode_q),
  .flag    (flag_q),
  .cks     (cks_q),
  .cnt     (cnt_q),
  .rst_req (wdt_rst_req)
);

// File: tb/keyed_wdt_tb_top.sv
`timescale 1ns/1ps
module keyed_wdt_tb_top;
  localparam logic [7:0] KC = 8'h5A;
  localparam logic [7:0] KS = 8'hA5;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0, wide = 1'b0, addr = 1'b0;
  logic [15:0] wdata = '0;
  logic [7:0]  rdata;
  logic        rst_req, irq;
  int          total = 0, bad = 0;

  always #2.5 clk = ~clk;

  keyed_wdt dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_wide(wide),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .wdt_rst_req(rst_req), .wdt_irq(irq)
  );

  function automatic logic [7:0] csr_exp(input logic e, input logic m, input logic f,
                                         input logic [2:0] c);
    return {e, m, f, 2'b00, c};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_w(input logic a, input logic w16, input logic [7:0] k, input logic [7:0] v);
    sel = 1'b1; wr = 1'b1; wide = w16; addr = a; wdata = {k, v};
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; wide = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    addr = a;
    #0.1;
    v = rdata;
  endtask

  task automatic chk_cnt(input string req, input logic [7:0] exp);
    logic [7:0] v;
    rd(1'b0, v);
    chk(req, v, exp);
  endtask

  task automatic chk_csr(input string req, input logic [7:0] exp);
    logic [7:0] v;
    rd(1'b1, v);
    chk(req, v, exp);
  endtask

  task automatic expect_step(input int p, input logic [7:0] base, input string req);
    repeat (p - 1) @(negedge clk);
    chk_cnt(req, base);
    @(negedge clk);
    chk_cnt(req, base + 8'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic       m_en, m_mode, old_en, a, w;
    logic [2:0] m_cks;
    logic [7:0] k, v;
    void'($urandom(32'h1bad5eed));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk_cnt("R1 counter", 8'h00);
    chk_csr("R1 csr", 8'h00);
    chk("R1 rst_req", rst_req, 0);
    chk("R1 irq", irq, 0);

    bus_w(1'b1, 1'b0, KS, 8'h80);
    chk_csr("R4 byte write", 8'h00);
    bus_w(1'b1, 1'b1, KC, 8'h80);
    chk_csr("R4 wrong key", 8'h00);
    bus_w(1'b0, 1'b1, KC, 8'h33);
    @(negedge clk);
    chk_cnt("R6 write while disabled", 8'h00);

    bus_w(1'b1, 1'b1, KS, 8'h9F);
    chk_csr("R3 R11 enable readback", 8'h87);
    expect_step(4096, 8'h00, "R5 code7 period");

    bus_w(1'b1, 1'b1, KS, 8'h81);
    chk_csr("R10 cks locked", 8'h87);

    bus_w(1'b0, 1'b1, KC, 8'hFE);
    chk_cnt("R2 load", 8'hFE);
    repeat (2 * 4096 - 1) @(negedge clk);
    chk_cnt("R7 pre-overflow", 8'hFF);
    chk("R9 irq before", irq, 0);
    @(negedge clk);
    chk_cnt("R7 wrap", 8'h00);
    chk_csr("R7 flag set", 8'hA7);
    chk("R9 irq", irq, 1);
    chk("R9 no rst_req", rst_req, 0);

    bus_w(1'b1, 1'b1, KS, 8'hA7);
    chk_csr("R7 write one keeps flag", 8'hA7);
    bus_w(1'b1, 1'b1, KS, 8'h80);
    chk_csr("R7 clear flag", 8'h87);
    chk("R9 irq cleared", irq, 0);

    bus_w(1'b1, 1'b1, KS, 8'h00);
    chk_csr("R10 disable keeps cks", 8'h07);
    @(negedge clk);
    chk_cnt("R6 held zero", 8'h00);
    bus_w(1'b1, 1'b1, KS, 8'h00);
    chk_csr("R10 cks while disabled", 8'h00);

    bus_w(1'b1, 1'b1, KS, 8'hC0);
    chk_csr("R3 watchdog mode", 8'hC0);
    bus_w(1'b0, 1'b1, KC, 8'hFE);
    expect_step(32, 8'hFE, "R5 code0 period");
    repeat (31) @(negedge clk);
    chk("R8 no early pulse", rst_req, 0);
    @(negedge clk);
    chk("R8 pulse", rst_req, 1);
    chk("R8 irq low", irq, 0);
    chk_csr("R8 flag", 8'hE0);
    @(negedge clk);
    chk("R8 one cycle", rst_req, 0);

    bus_w(1'b1, 1'b1, KS, 8'h80);
    chk_csr("R7 clear to interval", 8'h80);
    bus_w(1'b0, 1'b1, KC, 8'hFE);
    repeat (2 * 32 - 1) @(negedge clk);
    bus_w(1'b1, 1'b1, KS, 8'h80);
    chk_csr("R7 overflow beats clear", 8'hA0);
    chk("R9 irq same edge", irq, 1);
    bus_w(1'b1, 1'b1, KS, 8'h80);
    chk("R9 irq after clear", irq, 0);

    bus_w(1'b0, 1'b1, KC, 8'h10);
    repeat (15) @(negedge clk);
    bus_w(1'b0, 1'b1, KC, 8'h40);
    expect_step(32, 8'h40, "R2 prescaler cleared");
    bus_w(1'b0, 1'b1, KC, 8'h10);
    repeat (31) @(negedge clk);
    bus_w(1'b0, 1'b1, KC, 8'h50);
    chk_cnt("R2 write beats tick", 8'h50);

    bus_w(1'b1, 1'b1, KS, 8'h00);
    bus_w(1'b1, 1'b1, KS, 8'h02);
    bus_w(1'b1, 1'b1, KS, 8'h82);
    chk_csr("R5 code2 set", 8'h82);
    expect_step(128, 8'h00, "R5 code2 period");
    bus_w(1'b1, 1'b1, KS, 8'h00);
    bus_w(1'b1, 1'b1, KS, 8'h00);
    chk_csr("R10 back to code0", 8'h00);

    m_en = 1'b0; m_mode = 1'b0; m_cks = 3'd0;
    for (int i = 0; i < 300; i++) begin
      a = 1'($urandom % 2);
      w = ($urandom % 4) != 0;
      case ($urandom % 3)
        0: k = KC;
        1: k = KS;
        default: k = 8'($urandom);
      endcase
      v = 8'($urandom);
      if (!a) v[7] = 1'b0;
      old_en = m_en;
      bus_w(a, w, k, v);
      if (a && w && k == KS) begin
        if (!m_en) m_cks = v[2:0];
        m_en = v[7];
        m_mode = v[6];
      end
      chk_csr("R3 R4 R10 random csr", csr_exp(m_en, m_mode, 1'b0, m_cks));
      if (!old_en) chk_cnt("R6 random held", 8'h00);
      chk("R4 random no pulse", {rst_req, irq}, 0);
      repeat ($urandom % 3) @(negedge clk);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule